// File: doc/BRIEF.md
# Domain and Access Permission Checker

This block sits behind a translation lookaside buffer and decides, for one memory access at a time, whether that access may go ahead. It takes three groups of inputs. The first comes from the matching translation entry: the domain number and the permission bits. The second describes the access: whether it reads or writes, and whether it runs privileged or user. The third is the processor's control state: the 32-bit domain access control word and the two protection override bits, S and R.

Each domain has a 2-bit mode in the control word, and the mode decides how permissions are treated. A no-access domain faults every access. A manager domain lets every access through. A client domain checks the access against the permission bits. In those bits the extension bit picks read-only against read/write, and the upper AP bit picks user-accessible against kernel-only. The verdict appears one clock after the request as allow, or as abort with a fault code, from a single registered output stage.

Top module: `dapc_access_check`

## Requirements
- R1: Domain n is controlled by control-word bits [2n+1:2n]. Field value 00 means no access, 01 means client, 11 means manager, and the reserved value 10 behaves exactly like 00.
- R2: An access to a no-access domain aborts with fault code 01 (domain fault), whatever the permission bits, S, R, privilege or direction.
- R3: An access to a manager domain is allowed, whatever the permission bits, S, R, privilege or direction.
- R4: In a client domain with AP not 00, privileged reads are always allowed and privileged writes are allowed only when APX=0. User reads are allowed only when AP[1]=1. User writes are allowed only when APX=0 and AP=11.
- R5: In a client domain with APX=0 and AP=00, writes are denied at every privilege. Reads are allowed at any privilege when R=1. When R=0 and S=1 they are allowed for privileged accesses only. When both bits are clear, every read is denied.
- R6: In a client domain with APX=1 and AP=00 (reserved), every access is denied.
- R7: A denial in a client domain aborts with fault code 10 (permission fault).
- R8: The result of a request presented at one rising edge appears at the outputs after that edge and holds for one cycle, with rsp_valid high. A cycle with no request gives rsp_valid, rsp_allow and rsp_abort low and rsp_fault 00 in the following cycle.
- R9: While reset (active low) is held, all outputs are low.
- R10: When rsp_valid is high, exactly one of rsp_allow and rsp_abort is high, and rsp_fault is 00 exactly when rsp_allow is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A check request is present this cycle |
| req_domain | input | 4 | Domain number of the matching entry |
| req_apx | input | 1 | Permission extension bit (read-only select) |
| req_ap | input | 2 | Permission bits; bit 1 selects user access |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_priv | input | 1 | 1 = privileged access, 0 = user access |
| dacr | input | 32 | Domain access control word, 2 bits per domain |
| ctl_s | input | 1 | System protection override bit |
| ctl_r | input | 1 | ROM protection override bit |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_allow | output | 1 | Access may proceed |
| rsp_abort | output | 1 | Access is aborted |
| rsp_fault | output | 2 | 00 none, 01 domain fault, 10 permission fault |

## Verification
The bench sweeps every APX/AP pair against every S/R pair, in both directions and at both privilege levels, in a client domain. A decoder that swapped the roles of APX and AP[1], or gave S and R the wrong precedence, would then grant writes to read-only pages or grant user reads of kernel pages. Further directed cases program the reserved domain value 10, which a careless decoder would treat as a manager and let every access through. They also place a manager domain at index 15 among no-access neighbours, so a wrong field slice in the control word shows up. Random requests, with idle cycles in between, confirm that a fault code never goes stale after an allowed access and that an idle cycle clears the outputs.

// File: rtl/dapc_pkg.sv
package dapc_pkg;

    // Per-domain control field values
    typedef enum logic [1:0] {
        DOM_NOACC   = 2'b00,
        DOM_CLIENT  = 2'b01,
        DOM_RSVD    = 2'b10,
        DOM_MANAGER = 2'b11
    } dom_mode_e;

    // Fault code reported with an abort
    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_DOMAIN = 2'b01,
        FLT_PERM   = 2'b10,
        FLT_UNUSED = 2'b11
    } fault_e;

    // Rights granted by one set of permission bits
    typedef struct packed {
        logic priv_rd;
        logic priv_wr;
        logic user_rd;
        logic user_wr;
    } perm_t;

    // Registered response
    typedef struct packed {
        logic   valid;
        logic   allow;
        logic   abort;
        fault_e fault;
    } rsp_t;

endpackage

// File: rtl/dapc_domain_sel.sv
module dapc_domain_sel
    import dapc_pkg::*;
#(
    parameter  int NUM_DOMAINS = 16,
    localparam int IDX_W       = $clog2(NUM_DOMAINS),
    localparam int DACR_W      = 2 * NUM_DOMAINS
) (
    input  logic [DACR_W-1:0] dacr,
    input  logic [IDX_W-1:0]  domain,
    output dom_mode_e         mode
);

    logic [1:0] field [NUM_DOMAINS];

    for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_field
        assign field[g] = dacr[2*g +: 2];
    end

    always_comb begin
        unique case (field[domain])
            2'b01:   mode = DOM_CLIENT;
            2'b11:   mode = DOM_MANAGER;
            default: mode = DOM_NOACC;   // 00 and reserved 10 (R1)
        endcase
    end

endmodule

// File: rtl/dapc_perm_decode.sv
module dapc_perm_decode
    import dapc_pkg::*;
(
    input  logic       apx,
    input  logic [1:0] ap,
    input  logic       ctl_s,
    input  logic       ctl_r,
    output perm_t      perm
);

    always_comb begin
        perm = '0;
        unique case ({apx, ap})
            3'b0_00: begin                  // override bits decide (R5)
                perm.priv_rd = ctl_r | ctl_s;
                perm.user_rd = ctl_r;
            end
            3'b0_01: begin
                perm.priv_rd = 1'b1;
                perm.priv_wr = 1'b1;
            end
            3'b0_10: begin
                perm.priv_rd = 1'b1;
                perm.priv_wr = 1'b1;
                perm.user_rd = 1'b1;
            end
            3'b0_11: perm = '1;
            3'b1_00: perm = '0;             // reserved (R6)
            3'b1_01: perm.priv_rd = 1'b1;
            default: begin                  // 1_10, 1_11: read-only for all
                perm.priv_rd = 1'b1;
                perm.user_rd = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dapc_access_check.sv
module dapc_access_check
    import dapc_pkg::*;
#(
    parameter  int NUM_DOMAINS = 16,
    localparam int IDX_W       = $clog2(NUM_DOMAINS),
    localparam int DACR_W      = 2 * NUM_DOMAINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_domain,
    input  logic              req_apx,
    input  logic [1:0]        req_ap,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic [DACR_W-1:0] dacr,
    input  logic              ctl_s,
    input  logic              ctl_r,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic              rsp_abort,
    output logic [1:0]        rsp_fault
);

    dom_mode_e mode;
    perm_t     perm;
    logic      granted;
    rsp_t      rsp_d, rsp_q;

    dapc_domain_sel #(.NUM_DOMAINS(NUM_DOMAINS)) i_domain_sel (
        .dacr   (dacr),
        .domain (req_domain),
        .mode   (mode)
    );

    dapc_perm_decode i_perm_decode (
        .apx   (req_apx),
        .ap    (req_ap),
        .ctl_s (ctl_s),
        .ctl_r (ctl_r),
        .perm  (perm)
    );

    always_comb begin
        if (req_priv) granted = req_write ? perm.priv_wr : perm.priv_rd;
        else          granted = req_write ? perm.user_wr : perm.user_rd;

        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            unique case (mode)
                DOM_MANAGER: rsp_d.allow = 1'b1;
                DOM_CLIENT: begin
                    if (granted) begin
                        rsp_d.allow = 1'b1;
                    end else begin
                        rsp_d.abort = 1'b1;
                        rsp_d.fault = FLT_PERM;
                    end
                end
                default: begin
                    rsp_d.abort = 1'b1;
                    rsp_d.fault = FLT_DOMAIN;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_allow = rsp_q.allow;
    assign rsp_abort = rsp_q.abort;
    assign rsp_fault = rsp_q.fault;

    // R8: a request yields a result in the next cycle
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R8: an idle cycle leaves quiet outputs behind it
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_allow && !rsp_abort && rsp_fault == 2'b00));

    // R3: manager domains always pass
    p_manager_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == DOM_MANAGER) |=> rsp_allow);

    // R2: no-access domains always raise a domain fault
    p_noacc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == DOM_NOACC) |=> (rsp_abort && rsp_fault == 2'b01));

    // R10: exactly one verdict per result
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_allow, rsp_abort}) == 1);

    // R10: fault code matches the verdict
    p_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_allow == (rsp_fault == 2'b00)));

    // R7: a client denial reports a permission fault
    p_perm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == DOM_CLIENT && !granted) |=> (rsp_abort && rsp_fault == 2'b10));

endmodule

// File: tb/test_dapc_access_check.sv
module test_dapc_access_check;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [3:0]  req_domain;
    logic        req_apx;
    logic [1:0]  req_ap;
    logic        req_write;
    logic        req_priv;
    logic [31:0] dacr;
    logic        ctl_s;
    logic        ctl_r;
    logic        rsp_valid;
    logic        rsp_allow;
    logic        rsp_abort;
    logic [1:0]  rsp_fault;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    dapc_access_check i_dapc_access_check (
        .clk, .rst_n, .req_valid, .req_domain, .req_apx, .req_ap,
        .req_write, .req_priv, .dacr, .ctl_s, .ctl_r,
        .rsp_valid, .rsp_allow, .rsp_abort, .rsp_fault
    );

    // Expected {valid, allow, abort, fault[1:0]} from the requirements
    function automatic logic [4:0] expect_rsp(
        logic [3:0] d, logic apx, logic [1:0] ap, logic wr, logic pv,
        logic [31:0] ctl, logic s, logic r);
        logic [1:0] fld;
        logic       ok;
        fld = ctl[2*d +: 2];
        if (fld == 2'b11) return 5'b11000;                  // R3
        if (fld != 2'b01) return 5'b10101;                  // R1, R2
        if (ap == 2'b00) begin
            if (apx)     ok = 1'b0;                         // R6
            else if (wr) ok = 1'b0;                         // R5
            else         ok = r | (s & pv);
        end else if (pv) begin
            ok = wr ? !apx : 1'b1;                          // R4
        end else begin
            ok = wr ? (!apx && ap == 2'b11) : ap[1];
        end
        return ok ? 5'b11000 : 5'b10110;                    // R7
    endfunction

    function automatic string tag_of(logic [3:0] d, logic apx, logic [1:0] ap,
                                     logic [31:0] ctl);
        logic [1:0] fld;
        fld = ctl[2*d +: 2];
        if (fld == 2'b11) return "R3";
        if (fld == 2'b10) return "R1";
        if (fld == 2'b00) return "R2";
        if (ap == 2'b00) return apx ? "R6" : "R5";
        return "R4";
    endfunction

    task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_req(logic [3:0] d, logic apx, logic [1:0] ap, logic wr,
                          logic pv, logic [31:0] ctl, logic s, logic r);
        logic [4:0] e;
        logic [4:0] a;
        @(negedge clk);
        req_valid = 1'b1; req_domain = d; req_apx = apx; req_ap = ap;
        req_write = wr; req_priv = pv; dacr = ctl; ctl_s = s; ctl_r = r;
        e = expect_rsp(d, apx, ap, wr, pv, ctl, s, r);
        @(posedge clk);
        #1;
        a = {rsp_valid, rsp_allow, rsp_abort, rsp_fault};
        check(tag_of(d, apx, ap, ctl), a, e);
        // R7: abort codes; R10: exactly one verdict
        check("R10", {rsp_valid, 1'b0, rsp_allow ^ rsp_abort, 2'b00}, 5'b10100);
    endtask

    task automatic do_idle();
        @(negedge clk);
        req_valid  = 1'b0;
        req_domain = 4'($urandom);
        req_apx    = 1'($urandom);
        req_ap     = 2'($urandom);
        dacr       = 32'hFFFF_FFFF;
        @(posedge clk);
        #1;
        check("R8 idle", {rsp_valid, rsp_allow, rsp_abort, rsp_fault}, 5'b00000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1176));
        rst_n = 1'b0; req_valid = 1'b1; req_domain = '0; req_apx = 1'b0;
        req_ap = 2'b11; req_write = 1'b0; req_priv = 1'b1;
        dacr = 32'hFFFF_FFFF; ctl_s = 1'b0; ctl_r = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset", {rsp_valid, rsp_allow, rsp_abort, rsp_fault}, 5'b00000);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: field slicing at the top index, manager among no-access
        do_req(4'd15, 1'b1, 2'b00, 1'b1, 1'b0, 32'hC000_0000, 1'b0, 1'b0);
        do_req(4'd14, 1'b0, 2'b11, 1'b0, 1'b1, 32'hC000_0000, 1'b1, 1'b1);
        // R1: reserved value 10 acts as no access
        do_req(4'd0, 1'b0, 2'b11, 1'b0, 1'b1, 32'h0000_0002, 1'b0, 1'b0);
        do_req(4'd7, 1'b0, 2'b11, 1'b1, 1'b1, 32'h0000_8000, 1'b0, 1'b0);
        // R6 with manager: permissions ignored
        do_req(4'd3, 1'b1, 2'b00, 1'b1, 1'b0, 32'h0000_00C0, 1'b0, 1'b0);

        // R4, R5, R6, R7: full client sweep in domain 5
        for (int k = 0; k < 128; k++) begin
            do_req(4'd5, k[6], k[5:4], k[3], k[2], 32'h0000_0400, k[1], k[0]);
        end
        do_idle();

        // Random mix with idle gaps
        for (int i = 0; i < 1500; i++) begin
            if ($urandom_range(0, 7) == 0) begin
                do_idle();
            end else begin
                do_req(4'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
                       1'($urandom), $urandom, 1'($urandom), 1'($urandom));
            end
        end
        do_idle();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule